// File: doc/BRIEF.md
# Block-Stepped Word DMA Channel

This block is one DMA channel that moves 32-bit words from a source address to a destination address. It can also write a constant fill word to a run of destination addresses without reading anything. Software programs six registers through a simple write port. Setting the arm bit in the control register starts the channel. The channel then either runs at once or waits for pulses on an external request line.

Every run is cut into hardware blocks. A block counter limits each block, and a separate total counter follows the whole transfer. Control flags select:

- whether each address steps up, steps down or stays fixed;
- whether either address is reloaded from its register at each block start;
- whether the channel stays armed after a block (repeat) or disarms once the total is used up.

One request mode feeds a FIFO. In that mode each request moves at most 112 words, and the interrupted block carries on at the next request. While a block is moving, the channel holds the bus. It issues one memory access at a time over a valid/ready handshake.

Top module: `dma_word_channel`

## Requirements
- R1: After synchronous reset, `armed`, `hold`, `irq` and `mem_req` are all low.
- R2: Register selects are 0 source, 1 destination, 2 total length, 3 block length, 4 fill word and 5 control. The channel arms only when control bit 31 is written as 1 while it reads 0. Arming copies the source and destination registers into the working addresses and copies the total length into the total counter. Rewriting control while bit 31 is already set stores the value but reloads nothing.
- R3: Control bits 11:10 pick the destination step: 0 up, 1 down, 2 fixed, 3 acts as up.
- R4: Control bits 14:13 pick the source step: 0 up, 1 down, 2 fixed. Value 3 is fill mode: no read is issued and the fill register is written to each destination.
- R5: Control bits 28:24 hold the start mode, and any value above 0x10 is treated as 0x10. Mode 0x10 starts one block right after arming. Every other mode starts a block only on a high `trig` while the channel is armed and idle.
- R6: Each moved word changes a stepping address by 4 bytes.
- R7: A fresh block loads its counter from the block length register, and a length of 0 means 2^24 words.
- R8: When control bit 12 is set, the working destination address is reloaded from its register at every block start. Control bit 15 does the same for the source address.
- R9: Repeat is off when control bit 29 is 0. With repeat off and a triggered mode, a block is shortened to the words left in the total counter. With bit 29 set, blocks are never shortened.
- R10: In mode 0x10, bit 31 clears when the block ends. In a triggered mode with bit 29 clear, bit 31 clears when a block ends with the total counter at 0. With bit 29 set, bit 31 stays set.
- R11: When bit 31 is cleared by the channel and control bit 30 is set, `irq` is high for exactly one cycle.
- R12: In start mode 0x0A, one trigger moves at most 112 words. The next trigger continues the same block without reloading its counter.
- R13: `hold` is high from block start until the block or chunk ends, and is high whenever `mem_req` is high. An access whose `mem_ready` is low keeps its address and direction into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..5) |
| reg_wdata | input | 32 | Register write data |
| trig | input | 1 | External start request for triggered modes |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write to destination, 0 = read from source |
| mem_addr | output | AW (32) | Byte address of the access |
| mem_wdata | output | DW (32) | Data written |
| mem_rdata | input | DW (32) | Data returned for a read |
| mem_ready | input | 1 | Access completes in this cycle |
| hold | output | 1 | Bus held while a block or chunk moves |
| armed | output | 1 | Current value of control bit 31 |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench goes after these corner cases:

- **Total shorter than block.** A triggered non-repeat transfer has a total that is not a multiple of its block. A design that forgot to shorten the last block would write past the total and stay armed.
- **Repeat with a small total.** The same block shape with repeat on must not be cut. A design that shortened it would move too few words.
- **Zero block length.** A block length of zero must act as a huge block, not an empty one.
- **Rewrite while armed.** Rewriting control while already armed must not re-arm. A design that re-armed would jump back to the newly written destination instead of continuing.
- **FIFO mode.** A chunk of 112 must be followed by an 8-word remainder on the next request. A design that reloaded the block counter would move 112 again.
- **Fill mode.** Fill must issue zero reads.
- **Fixed, downward and reserved steps.** These are checked address by address under a memory that stalls at random.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [1:0] {
        STEP_UP    = 2'd0,
        STEP_DOWN  = 2'd1,
        STEP_FIXED = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_READ,
        ENG_WRITE,
        ENG_DONE
    } eng_state_e;

    localparam logic [2:0] SEL_SRC   = 3'd0;
    localparam logic [2:0] SEL_DST   = 3'd1;
    localparam logic [2:0] SEL_TOTAL = 3'd2;
    localparam logic [2:0] SEL_BLOCK = 3'd3;
    localparam logic [2:0] SEL_FILL  = 3'd4;
    localparam logic [2:0] SEL_CTRL  = 3'd5;

    localparam logic [4:0] MODE_IMMEDIATE = 5'h10;
    localparam logic [4:0] MODE_FIFO      = 5'h0A;

    localparam int CB_ARM        = 31;
    localparam int CB_IRQ        = 30;
    localparam int CB_RPT        = 29;
    localparam int CB_MODE_LO    = 24;
    localparam int CB_SRC_RELOAD = 15;
    localparam int CB_SRC_STEP   = 13;
    localparam int CB_DST_RELOAD = 12;
    localparam int CB_DST_STEP   = 10;

    typedef struct packed {
        step_e      src_step;
        step_e      dst_step;
        logic       fill;
        logic [4:0] mode;
        logic       rpt;
        logic       irq_en;
        logic       src_reload;
        logic       dst_reload;
    } chan_cfg_t;

    function automatic step_e dst_step_of(input logic [1:0] f);
        case (f)
            2'd1:    return STEP_DOWN;
            2'd2:    return STEP_FIXED;
            default: return STEP_UP;
        endcase
    endfunction

    function automatic step_e src_step_of(input logic [1:0] f);
        case (f)
            2'd0:    return STEP_UP;
            2'd1:    return STEP_DOWN;
            default: return STEP_FIXED;
        endcase
    endfunction

    function automatic logic [4:0] clamp_mode(input logic [4:0] m);
        return (m > MODE_IMMEDIATE) ? MODE_IMMEDIATE : m;
    endfunction

    function automatic chan_cfg_t decode_ctrl(input logic [31:0] c);
        chan_cfg_t r;
        r.src_step   = src_step_of(c[CB_SRC_STEP +: 2]);
        r.dst_step   = dst_step_of(c[CB_DST_STEP +: 2]);
        r.fill       = (c[CB_SRC_STEP +: 2] == 2'd3);
        r.mode       = clamp_mode(c[CB_MODE_LO +: 5]);
        r.rpt        = c[CB_RPT];
        r.irq_en     = c[CB_IRQ];
        r.src_reload = c[CB_SRC_RELOAD];
        r.dst_reload = c[CB_DST_RELOAD];
        return r;
    endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TOT_W = 32,
    parameter int BLK_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       sel,
    input  logic [31:0]      wdata,
    input  logic             clear_arm,
    output logic [AW-1:0]    src_reg,
    output logic [AW-1:0]    dst_reg,
    output logic [TOT_W-1:0] total_reg,
    output logic [BLK_W-1:0] block_reg,
    output logic [DW-1:0]    fill_reg,
    output logic             armed,
    output logic             arm_pulse,
    output logic             arm_immediate,
    output chan_cfg_t        cfg
);

    logic [31:0] ctrl_q;
    chan_cfg_t   cfg_q;
    chan_cfg_t   new_cfg;

    assign new_cfg       = decode_ctrl(wdata);
    assign arm_pulse     = we && (sel == SEL_CTRL) && wdata[CB_ARM] && !ctrl_q[CB_ARM];
    assign arm_immediate = arm_pulse && (new_cfg.mode == MODE_IMMEDIATE);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_reg   <= '0;
            dst_reg   <= '0;
            total_reg <= '0;
            block_reg <= '0;
            fill_reg  <= '0;
            ctrl_q    <= '0;
            cfg_q     <= '0;
        end else begin
            if (we) begin
                case (sel)
                    SEL_SRC:   src_reg   <= wdata[AW-1:0];
                    SEL_DST:   dst_reg   <= wdata[AW-1:0];
                    SEL_TOTAL: total_reg <= wdata[TOT_W-1:0];
                    SEL_BLOCK: block_reg <= wdata[BLK_W-1:0];
                    SEL_FILL:  fill_reg  <= wdata[DW-1:0];
                    default: ;
                endcase
            end
            if (we && sel == SEL_CTRL) begin
                ctrl_q <= wdata;
            end else if (clear_arm) begin
                ctrl_q[CB_ARM] <= 1'b0;
            end
            if (arm_pulse) begin
                cfg_q <= new_cfg;
            end
        end
    end

    assign armed = ctrl_q[CB_ARM];
    assign cfg   = cfg_q;

endmodule

// File: rtl/dmach_addr_step.sv
module dmach_addr_step
    import dmach_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_en,
    input  step_e         step,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] STRIDE = AW'(4);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step_en) begin
            case (step)
                STEP_UP:   addr <= addr + STRIDE;
                STEP_DOWN: addr <= addr - STRIDE;
                default:   addr <= addr;
            endcase
        end
    end

endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
    import dmach_pkg::*;
#(
    parameter int DW    = 32,
    parameter int TOT_W = 32,
    parameter int BLK_W = 24,
    parameter int CHUNK = 112
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic             arm_pulse,
    input  logic             arm_immediate,
    input  chan_cfg_t        cfg,
    input  logic [TOT_W-1:0] total_reg,
    input  logic [BLK_W-1:0] block_reg,
    input  logic [DW-1:0]    fill_reg,
    input  logic             trig,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_wdata,
    output logic             blk_start,
    output logic             word_done,
    output logic             clear_arm,
    output logic             irq,
    output logic             hold
);

    localparam int CNT_W = BLK_W + 1;
    localparam int CMP_W = (TOT_W > CNT_W) ? TOT_W : CNT_W;
    localparam logic [CNT_W-1:0] BLK_MAX = CNT_W'(1) << BLK_W;
    localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    eng_state_e       state_q;
    logic [CNT_W-1:0] iter_q, rem_q;
    logic [TOT_W-1:0] total_q;
    logic             in_prog_q, imm_go_q, irq_q;
    logic [DW-1:0]    data_q;

    logic             imm;
    logic [CNT_W-1:0] base_cnt, iter_cap, iter_pick, rem_pick;
    logic             start;

    assign imm = (cfg.mode == MODE_IMMEDIATE);

    always_comb begin
        base_cnt = in_prog_q ? rem_q
                 : ((block_reg == '0) ? BLK_MAX : CNT_W'(block_reg));
        iter_cap = ((cfg.mode == MODE_FIFO) && (base_cnt > CHUNK_C)) ? CHUNK_C : base_cnt;
        iter_pick = iter_cap;
        rem_pick  = base_cnt;
        if (!imm && !cfg.rpt && (CMP_W'(iter_cap) > CMP_W'(total_q))) begin
            iter_pick = CNT_W'(total_q);
            rem_pick  = CNT_W'(total_q);
        end
    end

    assign start = (state_q == ENG_IDLE) && armed && (imm_go_q || (!imm && trig));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ENG_IDLE;
            iter_q    <= '0;
            rem_q     <= '0;
            total_q   <= '0;
            in_prog_q <= 1'b0;
            imm_go_q  <= 1'b0;
            irq_q     <= 1'b0;
            data_q    <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        iter_q    <= iter_pick;
                        rem_q     <= rem_pick;
                        in_prog_q <= 1'b1;
                        imm_go_q  <= 1'b0;
                        if (iter_pick == '0)   state_q <= ENG_DONE;
                        else if (cfg.fill)     state_q <= ENG_WRITE;
                        else                   state_q <= ENG_READ;
                    end
                end
                ENG_READ: begin
                    if (mem_ready) begin
                        data_q  <= mem_rdata;
                        state_q <= ENG_WRITE;
                    end
                end
                ENG_WRITE: begin
                    if (mem_ready) begin
                        iter_q  <= iter_q - ONE_C;
                        rem_q   <= rem_q - ONE_C;
                        total_q <= total_q - TOT_W'(1);
                        if (iter_q == ONE_C)   state_q <= ENG_DONE;
                        else if (cfg.fill)     state_q <= ENG_WRITE;
                        else                   state_q <= ENG_READ;
                    end
                end
                default: begin
                    if (rem_q == '0) in_prog_q <= 1'b0;
                    state_q <= ENG_IDLE;
                end
            endcase
            if (arm_pulse) begin
                total_q   <= total_reg;
                in_prog_q <= 1'b0;
                imm_go_q  <= arm_immediate;
            end
            irq_q <= clear_arm && cfg.irq_en;
        end
    end

    assign clear_arm = (state_q == ENG_DONE) && (rem_q == '0)
                     && (imm || (!cfg.rpt && total_q == '0));
    assign mem_req   = (state_q == ENG_READ) || (state_q == ENG_WRITE);
    assign mem_we    = (state_q == ENG_WRITE);
    assign mem_wdata = cfg.fill ? fill_reg : data_q;
    assign blk_start = start;
    assign word_done = (state_q == ENG_WRITE) && mem_ready;
    assign hold      = (state_q != ENG_IDLE);
    assign irq       = irq_q;

    a_r13_req_under_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> hold);

    a_r13_wait_ready: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)));

    a_r11_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r4_fill_no_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !cfg.fill);

    a_r12_chunk_limit: assert property (@(posedge clk) disable iff (rst)
        (hold && cfg.mode == MODE_FIFO) |-> (iter_q <= CHUNK_C));

endmodule

// File: rtl/dma_word_channel.sv
module dma_word_channel
    import dmach_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TOT_W = 32,
    parameter int BLK_W = 24,
    parameter int CHUNK = 112
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic          trig,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          hold,
    output logic          armed,
    output logic          irq
);

    logic [AW-1:0]    src_reg, dst_reg, src_cur, dst_cur;
    logic [TOT_W-1:0] total_reg;
    logic [BLK_W-1:0] block_reg;
    logic [DW-1:0]    fill_reg;
    logic             arm_pulse, arm_immediate, clear_arm;
    logic             blk_start, word_done;
    chan_cfg_t        cfg;

    dmach_regs #(.AW(AW), .DW(DW), .TOT_W(TOT_W), .BLK_W(BLK_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .clear_arm(clear_arm), .src_reg(src_reg), .dst_reg(dst_reg),
        .total_reg(total_reg), .block_reg(block_reg), .fill_reg(fill_reg),
        .armed(armed), .arm_pulse(arm_pulse), .arm_immediate(arm_immediate),
        .cfg(cfg)
    );

    dmach_addr_step #(.AW(AW)) u_src (
        .clk(clk), .rst(rst),
        .load(arm_pulse || (blk_start && cfg.src_reload)),
        .load_val(src_reg), .step_en(word_done), .step(cfg.src_step),
        .addr(src_cur)
    );

    dmach_addr_step #(.AW(AW)) u_dst (
        .clk(clk), .rst(rst),
        .load(arm_pulse || (blk_start && cfg.dst_reload)),
        .load_val(dst_reg), .step_en(word_done), .step(cfg.dst_step),
        .addr(dst_cur)
    );

    dmach_engine #(.DW(DW), .TOT_W(TOT_W), .BLK_W(BLK_W), .CHUNK(CHUNK)) u_eng (
        .clk(clk), .rst(rst), .armed(armed), .arm_pulse(arm_pulse),
        .arm_immediate(arm_immediate), .cfg(cfg), .total_reg(total_reg),
        .block_reg(block_reg), .fill_reg(fill_reg), .trig(trig),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .blk_start(blk_start),
        .word_done(word_done), .clear_arm(clear_arm), .irq(irq), .hold(hold)
    );

    assign mem_addr = mem_we ? dst_cur : src_cur;

    a_r13_addr_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> $stable(mem_addr));

    a_r10_irq_follows_disarm: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(reg_we)) |-> !armed);

endmodule

// File: tb/sim_dma_word_channel.sv
module sim_dma_word_channel;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        trig = 1'b0;
    logic        mem_req, mem_we, hold, armed, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;

    logic [31:0] mem [0:255];
    int          exp_addr[$];
    int unsigned exp_data[$];
    int          tests = 0, fails = 0;
    int          irq_seen = 0, reads = 0, cyc = 0;
    logic [7:0]  lfsr = 8'h5A;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];

    dma_word_channel u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .trig(trig), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .hold(hold), .armed(armed), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // memory model and reference comparison, one step per clock
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = mem_req && (lfsr[1:0] != 2'b00);
        if (mem_req && mem_ready) begin
            chk(hold, "R13 hold during access", int'(hold), 1);
            if (mem_we) begin
                mem[mem_addr[9:2]] = mem_wdata;
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R2 unexpected write", int'(mem_addr), 0);
                end else begin
                    chk(mem_addr == exp_addr[0], "R6 write address", int'(mem_addr), exp_addr[0]);
                    chk(mem_wdata == exp_data[0], "R4 write data", int'(mem_wdata), int'(exp_data[0]));
                    void'(exp_addr.pop_front());
                    void'(exp_data.pop_front());
                end
            end else begin
                reads++;
            end
        end
        if (irq) irq_seen++;
        cyc++;
        if (cyc > WATCHDOG) begin
            chk(1'b0, "watchdog", cyc, WATCHDOG);
            finish_run();
        end
    end

    function automatic logic [31:0] mk_ctrl(input bit arm, input bit ien, input bit rpt,
            input int mode, input bit srel, input int sstep, input bit drel, input int dstep);
        return (32'(arm) << 31) | (32'(ien) << 30) | (32'(rpt) << 29) | (32'(mode) << 24)
             | (32'(srel) << 15) | (32'(sstep) << 13) | (32'(drel) << 12) | (32'(dstep) << 10);
    endfunction

    task automatic wr(input int sel, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic push_copy(input int s, input int sd, input int d, input int dd, input int n);
        for (int k = 0; k < n; k++) begin
            exp_addr.push_back(d);
            exp_data.push_back(mem[s[9:2]]);
            s += sd; d += dd;
        end
    endtask

    task automatic push_fill(input int d, input int dd, input int n, input logic [31:0] v);
        for (int k = 0; k < n; k++) begin
            exp_addr.push_back(d);
            exp_data.push_back(v);
            d += dd;
        end
    endtask

    task automatic settle(input string tag, input bit exp_armed, input int irq0, input int exp_irq);
        int guard = 0;
        repeat (3) @(negedge clk);
        while (hold && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
        chk(exp_addr.size() == 0, {tag, " all words moved"}, exp_addr.size(), 0);
        chk(armed == exp_armed, {tag, " armed"}, int'(armed), int'(exp_armed));
        chk(irq_seen - irq0 == exp_irq, {tag, " irq pulses"}, irq_seen - irq0, exp_irq);
        exp_addr.delete();
        exp_data.delete();
    endtask

    initial begin
        int i0, r0;
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 | 32'(i);
        repeat (3) @(negedge clk);
        chk(!armed && !hold && !irq && !mem_req, "R1 reset state",
            int'({armed, hold, irq, mem_req}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!armed && !hold && !mem_req, "R1 after release", int'({armed, hold, mem_req}), 0);

        // R5 R6 R10 R11: immediate copy, both addresses stepping up
        wr(0, 32'h010); wr(1, 32'h200); wr(3, 4);
        i0 = irq_seen;
        push_copy(32'h010, 4, 32'h200, 4, 4);
        wr(5, mk_ctrl(1, 1, 0, 'h10, 0, 0, 0, 0));
        settle("R10 immediate", 1'b0, i0, 1);

        // R3 R4: destination down, source fixed, irq disabled (R11)
        wr(0, 32'h040); wr(1, 32'h23C); wr(3, 3);
        i0 = irq_seen;
        push_copy(32'h040, 0, 32'h23C, -4, 3);
        wr(5, mk_ctrl(1, 0, 0, 'h10, 0, 2, 0, 1));
        settle("R3 down/fixed no-irq R11", 1'b0, i0, 0);

        // R4 fill mode: no reads
        wr(4, 32'hA5A50F0F); wr(1, 32'h240); wr(3, 5);
        i0 = irq_seen; r0 = reads;
        push_fill(32'h240, 4, 5, 32'hA5A50F0F);
        wr(5, mk_ctrl(1, 1, 0, 'h10, 0, 3, 0, 0));
        settle("R4 fill", 1'b0, i0, 1);
        chk(reads == r0, "R4 fill issues no reads", reads - r0, 0);

        // R5 clamp 0x1F -> immediate, R3 destination code 3 acts as up
        wr(0, 32'h080); wr(1, 32'h260); wr(3, 2);
        i0 = irq_seen;
        push_copy(32'h080, 4, 32'h260, 4, 2);
        wr(5, mk_ctrl(1, 1, 0, 'h1F, 0, 0, 0, 3));
        settle("R5 clamp", 1'b0, i0, 1);

        // R9 R10 R2: triggered non-repeat, total 10 block 4
        wr(0, 32'h100); wr(1, 32'h280); wr(2, 10); wr(3, 4);
        i0 = irq_seen;
        wr(5, mk_ctrl(1, 1, 0, 'h04, 0, 0, 0, 0));
        repeat (20) @(negedge clk);
        chk(!hold && !mem_req, "R5 waits for trigger", int'({hold, mem_req}), 0);
        push_copy(32'h100, 4, 32'h280, 4, 4);
        pulse_trig();
        settle("R9 first block", 1'b1, i0, 0);
        wr(1, 32'h300);
        wr(5, mk_ctrl(1, 1, 0, 'h04, 0, 0, 0, 0));
        push_copy(32'h110, 4, 32'h290, 4, 4);
        pulse_trig();
        settle("R2 rewrite does not re-arm", 1'b1, i0, 0);
        push_copy(32'h120, 4, 32'h2A0, 4, 2);
        pulse_trig();
        settle("R9 last block cut", 1'b0, i0, 1);

        // R8 R9: repeat, block 3 total 2, destination reload
        wr(0, 32'h020); wr(1, 32'h2C0); wr(2, 2); wr(3, 3);
        i0 = irq_seen;
        wr(5, mk_ctrl(1, 1, 1, 'h04, 0, 0, 1, 0));
        push_copy(32'h020, 4, 32'h2C0, 4, 3);
        pulse_trig();
        settle("R9 repeat not cut", 1'b1, i0, 0);
        push_copy(32'h02C, 4, 32'h2C0, 4, 3);
        pulse_trig();
        settle("R8 dst reload", 1'b1, i0, 0);
        wr(5, 0);

        // R8: source reload
        wr(0, 32'h030); wr(1, 32'h2E0); wr(3, 2);
        i0 = irq_seen;
        wr(5, mk_ctrl(1, 0, 1, 'h02, 1, 0, 0, 0));
        push_copy(32'h030, 4, 32'h2E0, 4, 2);
        pulse_trig();
        settle("R8 src reload a", 1'b1, i0, 0);
        push_copy(32'h030, 4, 32'h2E8, 4, 2);
        pulse_trig();
        settle("R8 src reload b", 1'b1, i0, 0);
        wr(5, 0);

        // R12: FIFO mode chunks, 120 words
        wr(0, 32'h000); wr(1, 32'h200); wr(2, 120); wr(3, 120);
        i0 = irq_seen;
        wr(5, mk_ctrl(1, 1, 0, 'h0A, 0, 0, 0, 0));
        push_copy(32'h000, 4, 32'h200, 4, 112);
        pulse_trig();
        settle("R12 first chunk", 1'b1, i0, 0);
        push_copy(32'h1C0, 4, 32'h3C0, 4, 8);
        pulse_trig();
        settle("R12 resumed chunk", 1'b0, i0, 1);

        // R7: block length 0 is huge, cut to total 6
        wr(0, 32'h050); wr(1, 32'h300); wr(2, 6); wr(3, 0);
        i0 = irq_seen;
        wr(5, mk_ctrl(1, 1, 0, 'h01, 0, 0, 0, 0));
        push_copy(32'h050, 4, 32'h300, 4, 6);
        pulse_trig();
        settle("R7 zero block length", 1'b0, i0, 1);

        finish_run();
    end

endmodule